// File: doc/BRIEF.md
# Pipelined Floating-Point Divider with Taylor Reciprocal Table

This block divides one floating-point word by another in a fixed-latency pipeline that accepts a new operand pair on every clock. The exponent and fraction widths are parameters. The default is an 8-bit exponent with a 23-bit fraction. A word is packed with the sign in the MSB, then the biased exponent, then the fraction. An exponent field of zero means the value is zero.

The significand quotient does not use digit recurrence. The divisor significand is split into a high part and a low part. The high part addresses a table of reciprocal squares, which is computed at elaboration. One multiplier forms dividend times (high minus low), and a second multiplier scales that product by the table entry. A final stage normalizes the quotient, applies the sign and the biased exponent, and replaces zero, divide-by-zero and out-of-range cases with a zero word.

A valid flag and an exception flag travel alongside the data through every stage. This lets the divider sit inside a longer arithmetic chain without any extra control logic.

Top module: `fp_taylor_div`

## Requirements
- R1: An operation sampled at a rising edge with `ready_i` high appears on `quo_o` after `LAT` register stages, which means it is visible after `LAT`−1 further rising edges. `LAT` is 14 when `FRAC_W` > 11 and 10 otherwise. One operation is accepted per cycle with no stall.
- R2: `done_o` equals `ready_i` delayed by exactly `LAT` register stages.
- R3: `exc_o` equals `exc_i` delayed by `LAT` stages, ORed with any exception detected locally for that operation. Local detection applies only when `ready_i` was high. `exc_i` still passes through when `ready_i` is low.
- R4: For a nonzero, in-range result:
  - the sign bit is the XOR of the operand signs;
  - the exponent field is e_dividend − e_divisor + bias − s, where bias = 2^(EXP_W−1)−1 and s is the normalization shift from R6.
- R5: With significands X and Y taken as 2m-bit integers (hidden 1 made explicit) and Y split as Yh = Y >> m and Yl = Y mod 2^m:
  - the table entry is R = floor(2^(4m−1) / Yh²);
  - P1 = floor(X·(Yh·2^m − Yl) / 2^(2m−2));
  - the quotient word is Q = floor(P1·R / 2^(2m+1)), which is below 2^(2m+1).
- R6: The fraction depends on the top bits of Q:
  - if bit 2m of Q is set, the fraction is Q[2m−1:1] and s = 0;
  - else if bit 2m−1 is set, the fraction is Q[2m−2:0] and s = 1;
  - otherwise the fraction is zero and s = 1.
- R7: A zero dividend with a nonzero divisor gives an all-zero word and no local exception.
- R8: A zero divisor gives an all-zero word and raises `exc_o`.
- R9: If the final exponent is ≤ 0 or ≥ 2^EXP_W−1, the result is an all-zero word and `exc_o` is raised. A valid result never carries an all-ones exponent field.
- R10: While `rst_ni` is low, `done_o`, `exc_o` and `quo_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 1 | Operand pair valid this cycle |
| exc_i | input | 1 | Upstream exception flag |
| dvd_i | input | 1+EXP_W+FRAC_W | Dividend word |
| dvs_i | input | 1+EXP_W+FRAC_W | Divisor word |
| quo_o | output | 1+EXP_W+FRAC_W | Quotient word |
| done_o | output | 1 | Result valid, delayed `ready_i` |
| exc_o | output | 1 | Delayed `exc_i` ORed with local exceptions |

## Verification
An inherited exception on `exc_i` and a locally detected fault, such as a zero divisor or an exponent overflow, can land on the same operation. Both must merge into one `exc_o` pulse without losing the zero substitution on `quo_o`. The bench provokes this by driving `exc_i` together with a zero divisor. It also drives `exc_i` during bubbles, where no local detection may occur. A behavioural model decides each cycle whether the flag comes from one source, the other, or both. Back-to-back random operations with sparse bubbles check that the flag, the data and `done_o` stay aligned while a different fault sits in each stage.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;
  localparam int unsigned CORE_STAGES = 4;

  function automatic int unsigned tdiv_latency(int unsigned frac_w);
    return (frac_w > 11) ? 14 : 10;
  endfunction
endpackage

// File: rtl/tdiv_recip_rom.sv
module tdiv_recip_rom #(
  parameter int unsigned M = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [M-2:0]     idx_i,
  output logic [2*M+1:0]   val_o
);
  localparam int unsigned N     = 1 << (M - 1);
  localparam int unsigned OUT_W = 2 * M + 2;
  localparam int unsigned CW    = 4 * M + 2;

  function automatic logic [OUT_W-1:0] recip_sq(int unsigned k);
    logic [CW-1:0] num, yh, den;
    num = '0;
    num[4*M-1] = 1'b1;
    yh  = CW'((1 << (M - 1)) + k);
    den = yh * yh;
    return OUT_W'(num / den);
  endfunction

  logic [OUT_W-1:0] tbl [N];

  for (genvar g = 0; g < N; g++) begin : g_tbl
    localparam logic [OUT_W-1:0] ENTRY = recip_sq(g);
    assign tbl[g] = ENTRY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_o <= '0;
    else         val_o <= tbl[idx_i];
  end
endmodule

// File: rtl/tdiv_norm.sv
module tdiv_norm #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  parameter int unsigned M      = 12
) (
  input  logic                    valid_i,
  input  logic                    exc_i,
  input  logic                    sign_i,
  input  logic                    zx_i,
  input  logic                    zy_i,
  input  logic [EXP_W+1:0]        expd_i,
  input  logic [2*M:0]            qw_i,
  output logic [EXP_W+FRAC_W:0]   word_o,
  output logic                    exc_o
);
  localparam int unsigned EW = EXP_W + 2;
  localparam logic signed [EW-1:0] EMAX_S = EW'((1 << EXP_W) - 1);

  logic [2*M-2:0]          frac_full;
  logic                    adj;
  logic signed [EW-1:0]    e_fin;
  logic                    uf, of, zero_res, loc_exc;
  logic [FRAC_W-1:0]       frac;

  always_comb begin
    if (qw_i[2*M]) begin
      frac_full = qw_i[2*M-1:1];
      adj       = 1'b0;
    end else if (qw_i[2*M-1]) begin
      frac_full = qw_i[2*M-2:0];
      adj       = 1'b1;
    end else begin
      // quotient fell below one half after truncation
      frac_full = '0;
      adj       = 1'b1;
    end
  end

  assign e_fin    = $signed(expd_i) - $signed({{(EW-1){1'b0}}, adj});
  assign uf       = (e_fin <= 0);
  assign of       = (e_fin >= EMAX_S);
  assign zero_res = zx_i | zy_i | uf | of;
  assign loc_exc  = valid_i & (zy_i | (~zx_i & (uf | of)));
  assign exc_o    = exc_i | loc_exc;
  assign frac     = FRAC_W'(frac_full >> (2 * M - 1 - FRAC_W));
  assign word_o   = zero_res ? '0 : {sign_i, e_fin[EXP_W-1:0], frac};
endmodule

// File: rtl/tdiv_delay.sv
module tdiv_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  if (DEPTH == 0) begin : g_pass
    assign d_o = d_i;
  end else begin : g_pipe
    logic [W-1:0] pipe_q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k < DEPTH; k++) pipe_q[k] <= '0;
      end else begin
        pipe_q[0] <= d_i;
        for (int k = 1; k < DEPTH; k++) pipe_q[k] <= pipe_q[k-1];
      end
    end
    assign d_o = pipe_q[DEPTH-1];
  end
endmodule

// File: rtl/fp_taylor_div.sv
module fp_taylor_div
  import tdiv_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ready_i,
  input  logic                    exc_i,
  input  logic [EXP_W+FRAC_W:0]   dvd_i,
  input  logic [EXP_W+FRAC_W:0]   dvs_i,
  output logic [EXP_W+FRAC_W:0]   quo_o,
  output logic                    done_o,
  output logic                    exc_o
);
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;
  localparam int unsigned SIG_W  = FRAC_W + 1;
  localparam int unsigned SIG_P  = SIG_W + (SIG_W % 2);
  localparam int unsigned M      = SIG_P / 2;
  localparam int unsigned EW     = EXP_W + 2;
  localparam int unsigned LAT    = tdiv_latency(FRAC_W);
  localparam int unsigned TAIL   = LAT - CORE_STAGES;
  localparam int unsigned BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam logic [2*M+1:0] RLO = (2*M+2)'(1) << (2*M-1);
  localparam logic [2*M+1:0] RHI = (2*M+2)'(1) << (2*M+1);

  typedef struct packed {
    logic          valid;
    logic          exc_in;
    logic          sign;
    logic          zx;
    logic          zy;
    logic [EW-1:0] expd;
  } meta_t;

  typedef struct packed {
    meta_t          m;
    logic [2*M-1:0] x;
    logic [2*M-1:0] yd;
    logic [M-2:0]   idx;
  } s1_t;

  typedef struct packed {
    meta_t          m;
    logic [2*M+1:0] p1t;
  } s2_t;

  typedef struct packed {
    meta_t        m;
    logic [2*M:0] qw;
  } s3_t;

  // ---- stage 1: unpack, split divisor, exponent difference
  s1_t            s1_d, s1_q;
  logic [SIG_W-1:0] x_raw, y_raw;
  logic [2*M-1:0] y_sig;
  logic [M-1:0]   y_hi, y_lo;
  logic [EXP_W-1:0] ea, eb;

  assign ea    = dvd_i[WORD_W-2 -: EXP_W];
  assign eb    = dvs_i[WORD_W-2 -: EXP_W];
  assign x_raw = {1'b1, dvd_i[FRAC_W-1:0]};
  assign y_raw = {1'b1, dvs_i[FRAC_W-1:0]};
  assign y_sig = (2*M)'(y_raw) << (SIG_P - SIG_W);
  assign y_hi  = y_sig[2*M-1:M];
  assign y_lo  = y_sig[M-1:0];

  always_comb begin
    s1_d.m.valid  = ready_i;
    s1_d.m.exc_in = exc_i;
    s1_d.m.sign   = dvd_i[WORD_W-1] ^ dvs_i[WORD_W-1];
    s1_d.m.zx     = (ea == '0);
    s1_d.m.zy     = (eb == '0);
    s1_d.m.expd   = EW'(ea) - EW'(eb) + EW'(BIAS);
    s1_d.x        = (2*M)'(x_raw) << (SIG_P - SIG_W);
    s1_d.yd       = {y_hi, {M{1'b0}}} - {{M{1'b0}}, y_lo};
    s1_d.idx      = y_hi[M-2:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s1_q <= '0;
    else         s1_q <= s1_d;
  end

  // ---- stage 2: first multiply, table read in parallel
  s2_t            s2_q;
  logic [4*M-1:0] p1;
  logic [2*M+1:0] rom_val;

  assign p1 = s1_q.x * s1_q.yd;

  tdiv_recip_rom #(.M(M)) u_rom (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  (s1_q.idx),
    .val_o  (rom_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s2_q <= '0;
    else begin
      s2_q.m   <= s1_q.m;
      s2_q.p1t <= (2*M+2)'(p1 >> (2*M-2));
    end
  end

  // ---- stage 3: second multiply
  s3_t            s3_q;
  logic [4*M+3:0] p2;

  assign p2 = s2_q.p1t * rom_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s3_q <= '0;
    else begin
      s3_q.m  <= s2_q.m;
      s3_q.qw <= (2*M+1)'(p2 >> (2*M+1));
    end
  end

  // ---- stage 4: normalize, range check, pack
  logic [WORD_W-1:0] word_d;
  logic              exc_d;
  logic [WORD_W+1:0] s4_q, tail_o;

  tdiv_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .M(M)) u_norm (
    .valid_i (s3_q.m.valid),
    .exc_i   (s3_q.m.exc_in),
    .sign_i  (s3_q.m.sign),
    .zx_i    (s3_q.m.zx),
    .zy_i    (s3_q.m.zy),
    .expd_i  (s3_q.m.expd),
    .qw_i    (s3_q.qw),
    .word_o  (word_d),
    .exc_o   (exc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s4_q <= '0;
    else         s4_q <= {s3_q.m.valid, exc_d, word_d};
  end

  tdiv_delay #(.W(WORD_W + 2), .DEPTH(TAIL)) u_tail (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (s4_q),
    .d_o    (tail_o)
  );

  assign done_o = tail_o[WORD_W+1];
  assign exc_o  = tail_o[WORD_W];
  assign quo_o  = tail_o[WORD_W-1:0];

  // ---- assertions
  AST_RECIP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_q.m.valid |-> (rom_val > RLO) && (rom_val <= RHI)); // R5

  AST_QUOT_BELOW_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_q.m.valid |-> ((p2 >> (4*M+2)) == '0)); // R5

  AST_NO_RESERVED_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (quo_o[WORD_W-2 -: EXP_W] != '1)); // R9

  AST_ZERO_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (quo_o[WORD_W-2 -: EXP_W] == '0)) |-> (quo_o == '0)); // R7
endmodule

// File: tb/fp_taylor_div_test.sv
module fp_taylor_div_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        ready = 1'b0;
  logic        exc_in = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [31:0] quo;
  logic        done, exc;

  fp_taylor_div uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .ready_i(ready),
    .exc_i  (exc_in),
    .dvd_i  (a),
    .dvs_i  (b),
    .quo_o  (quo),
    .done_o (done),
    .exc_o  (exc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic        done;
    logic        exc;
    logic [31:0] res;
    string       tag;
  } exp_t;

  exp_t  q[$];
  string cur_tag = "R1";
  int    n_vec = 0;
  int    n_bad = 0;
  bit    finished = 0;

  function automatic exp_t model(logic [31:0] x, logic [31:0] y, logic rdy, logic xin, string tag);
    longint unsigned xs, ys, yh, yl, r, p1, p2, qw, fr;
    int   e, adj;
    bit   zx, zy, uf, of;
    exp_t o;
    zx = (x[30:23] == 8'd0);
    zy = (y[30:23] == 8'd0);
    xs = {40'd0, 1'b1, x[22:0]};
    ys = {40'd0, 1'b1, y[22:0]};
    yh = ys >> 12;
    yl = ys & 64'hFFF;
    r  = (64'd1 << 47) / (yh * yh);
    p1 = (xs * ((yh << 12) - yl)) >> 22;
    p2 = p1 * r;
    qw = p2 >> 25;
    if ((qw >> 24) != 0) begin
      fr = (qw >> 1) & 64'h7FFFFF; adj = 0;
    end else if (((qw >> 23) & 1) != 0) begin
      fr = qw & 64'h7FFFFF; adj = 1;
    end else begin
      fr = 0; adj = 1;
    end
    e  = int'(x[30:23]) - int'(y[30:23]) + 127 - adj;
    uf = (e <= 0);
    of = (e >= 255);
    o.done = rdy;
    o.exc  = xin | (rdy & (zy | (!zx & (uf | of))));
    o.res  = (zx || zy || uf || of) ? 32'd0 : {x[31] ^ y[31], e[7:0], fr[22:0]};
    o.tag  = tag;
    return o;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) q.push_back(model(a, b, ready, exc_in, cur_tag));
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (q.size() == LAT) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        if (done !== e.done || exc !== e.exc || (e.done && quo !== e.res)) begin
          n_bad++;
          $display("FAIL %s done=%0b/%0b exc=%0b/%0b quo=%h/%h (actual/expected)",
                   e.tag, done, e.done, exc, e.exc, quo, e.res);
        end
      end else begin
        // pipeline still filling: only bubbles may be visible (R1)
        n_vec++;
        if (done !== 1'b0 || exc !== 1'b0) begin
          n_bad++;
          $display("FAIL R1 fill done=%0b/0 exc=%0b/0", done, exc);
        end
      end
    end
  end

  task automatic send(logic [31:0] x, logic [31:0] y, logic rdy, logic xin, string tag);
    @(negedge clk);
    a = x; b = y; ready = rdy; exc_in = xin; cur_tag = tag;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog expired");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    a = 32'h3F800000; b = 32'h3F800000; ready = 1'b1; exc_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (done !== 1'b0 || exc !== 1'b0 || quo !== 32'd0) begin
      n_bad++;
      $display("FAIL R10 reset done=%0b/0 exc=%0b/0 quo=%h/00000000", done, exc, quo);
    end
    ready = 1'b0; exc_in = 1'b0;
    rst_n = 1'b1;

    // R4 sign and exponent, exact quotients
    send(32'h3F800000, 32'h3F800000, 1, 0, "R4");
    send(32'h40C00000, 32'h40400000, 1, 0, "R4");
    send(32'hC0000000, 32'h40400000, 1, 0, "R4");
    send(32'h3F800000, 32'hC0400000, 1, 0, "R4");
    // R6 normalization paths, including the below-half case
    send(32'h3F800000, 32'h3FFFFFFF, 1, 0, "R6");
    send(32'h3FFFFFFF, 32'h3F800000, 1, 0, "R6");
    send(32'h3FC00000, 32'h3FE00000, 1, 0, "R6");
    // R7 zero dividend
    send(32'h00000000, 32'h40400000, 1, 0, "R7");
    send(32'h80000000, 32'h3F800000, 1, 0, "R7");
    // R8 zero divisor
    send(32'h40400000, 32'h00000000, 1, 0, "R8");
    send(32'h00000000, 32'h00000000, 1, 0, "R8");
    // R9 exponent range edges
    send(32'h7F000000, 32'h00800000, 1, 0, "R9");
    send(32'h00800000, 32'h7F000000, 1, 0, "R9");
    send(32'h3F800000, 32'h7E800000, 1, 0, "R9");
    send(32'h3F800000, 32'h7F000000, 1, 0, "R9");
    send(32'h7F000000, 32'h3F800000, 1, 0, "R9");
    send(32'h7F000000, 32'h3F000000, 1, 0, "R9");
    // R3 inherited and local exceptions, alone and together
    send(32'h40400000, 32'h3F800000, 1, 1, "R3");
    send(32'h40400000, 32'h3F800000, 0, 1, "R3");
    send(32'h40400000, 32'h00000000, 1, 1, "R3");
    send(32'h40400000, 32'h00000000, 0, 0, "R3");
    send(32'h7F000000, 32'h00800000, 0, 1, "R3");
    // R2 bubbles interleaved with work
    for (int i = 0; i < 12; i++)
      send(32'h40000000 + i, 32'h3FA00000 + (i << 12), (i % 2) == 0, 0, "R2");
    // R1 back-to-back directed stream
    for (int i = 0; i < 40; i++)
      send({1'b0, 8'd120 + 8'(i % 16), 23'(i * 32'h1F3A7)},
           {1'b0, 8'd127, 23'(i * 32'h2B1C5)}, 1, 0, "R1");
    // R5 random operands, sparse bubbles and upstream exceptions
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if ((i % 4) != 0) begin
        ra[30:23] = 8'd64 + 8'($urandom_range(0, 127));
        rb[30:23] = 8'd64 + 8'($urandom_range(0, 127));
      end
      send(ra, rb, ($urandom_range(0, 9) != 0), ($urandom_range(0, 19) == 0), "R5");
    end
    send(32'd0, 32'd0, 0, 0, "R2");
    repeat (LAT + 4) @(negedge clk);
    finish_run();
  end
endmodule